// File: doc/BRIEF.md
# Flag-Producing ALU with Branch Evaluator

This block is the integer datapath of a small 16-bit processor. Each cycle it can execute one of eight operations on a first source and a second source. The second source is either a register value or an immediate. The operations are add, subtract, AND, OR, XOR, byte sign-extend, shift left and shift right. The result is registered and presented on the following cycle.

Every operation also writes a four-bit status register holding negative, zero, overflow and carry. Software can read that register back through `flags_o`. It can also overwrite it through a dedicated write port, and that write wins over a concurrent operation.

A branch evaluator combines the current status register with a condition code and reports, in the same cycle, whether the branch is taken. Register file, program counter update and immediate decoding are done outside the block.

Top module: `flag_alu`

## Requirements
- R1: While `rst_ni` is low, `result_o` and `flags_o` are zero.
- R2: With `use_imm_i` high, `imm_i` is the second operand and `src_b_i` has no effect. With `use_imm_i` low, `src_b_i` is the second operand.
- R3: Opcode 0 (add) gives A+B modulo 2^16. C is the carry out of bit 15. V is set when both operands have the same sign and the result's sign differs.
- R4: Opcode 1 (subtract) gives A-B modulo 2^16. C is set when no borrow occurs (A >= B unsigned). V is set when the operands differ in sign and the result's sign differs from A.
- R5: Opcodes 2, 3 and 4 give A AND B, A OR B and A XOR B, and clear V and C.
- R6: Opcode 5 (sign-extend) takes the low 8 bits of the second operand and copies bit 7 into bits 15..8. It clears V and C.
- R7: Opcode 6 shifts the second operand left by one and opcode 7 shifts it right by one, logically with a zero fill. C receives the bit shifted out and V is cleared.
- R8: The status layout is bit 3 N, bit 2 Z, bit 1 V, bit 0 C. After every operation, N equals result bit 15 and Z is set exactly when the result is zero.
- R9: `result_o` and `flags_o` change on the clock edge that samples `op_valid_i` high. With neither `op_valid_i` nor `stat_we_i` high, both hold their values.
- R10: With `stat_we_i` high, `flags_o` takes `stat_wdata_i` at the next edge. This holds even when an operation is issued in the same cycle, and in that case `result_o` still updates.
- R11: `br_taken_o` is computed combinationally from `cond_i` and the current `flags_o`. The codes are: 0 taken when Z=1, 1 taken when Z=0, 2 taken when N=1, 3 taken when V=1, 4 taken when C=1, 5 always taken, 6 and 7 never taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Execute the operation this cycle |
| op_i | input | 3 | Operation code |
| src_a_i | input | 16 | First register operand |
| src_b_i | input | 16 | Second register operand |
| imm_i | input | 16 | Immediate operand |
| use_imm_i | input | 1 | Select immediate as second operand |
| cond_i | input | 3 | Branch condition code |
| stat_we_i | input | 1 | Overwrite the status register |
| stat_wdata_i | input | 4 | Status write data {N,Z,V,C} |
| result_o | output | 16 | Registered result |
| flags_o | output | 4 | Status register {N,Z,V,C} |
| br_taken_o | output | 1 | Branch decision |

## Verification
An operation is sampled at one rising edge. Its result and flags are due one register later, just after that same edge, and `br_taken_o` follows `flags_o` with no register in between. The driver presents each operation at a falling edge and queues the predicted result and flags. A monitor pops one item per issued cycle and compares it shortly after the next rising edge. Idle cycles queue the unchanged state, so holding is checked too. Branch decisions are swept over all eight codes in the middle of idle cycles, against the flags the model predicts for that cycle.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4,
    OP_SGX = 3'd5,
    OP_SHL = 3'd6,
    OP_SHR = 3'd7
  } alu_op_e;

  typedef enum logic [2:0] {
    BR_EQ  = 3'd0,
    BR_NE  = 3'd1,
    BR_NEG = 3'd2,
    BR_OVF = 3'd3,
    BR_CRY = 3'd4,
    BR_ALW = 3'd5,
    BR_NV6 = 3'd6,
    BR_NV7 = 3'd7
  } br_cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

  localparam int unsigned FLAG_W = $bits(flags_t);

endpackage

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int unsigned W     = 16,
  parameter int unsigned SGX_W = 8
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output flags_t       flags_o
);

  localparam int unsigned MSB = W - 1;
  localparam int unsigned EXT = W - SGX_W;

  logic [W:0]   sum_w;
  logic [W:0]   dif_w;
  logic [W-1:0] res;
  logic         v_f;
  logic         c_f;

  assign sum_w = {1'b0, a_i} + {1'b0, b_i};
  // borrow-free carry convention: a + ~b + 1
  assign dif_w = {1'b0, a_i} + {1'b0, ~b_i} + {{W{1'b0}}, 1'b1};

  always_comb begin
    res = '0;
    v_f = 1'b0;
    c_f = 1'b0;
    unique case (op_i)
      OP_ADD: begin
        res = sum_w[W-1:0];
        c_f = sum_w[W];
        v_f = (a_i[MSB] == b_i[MSB]) && (res[MSB] != a_i[MSB]);
      end
      OP_SUB: begin
        res = dif_w[W-1:0];
        c_f = dif_w[W];
        v_f = (a_i[MSB] != b_i[MSB]) && (res[MSB] != a_i[MSB]);
      end
      OP_AND: res = a_i & b_i;
      OP_OR:  res = a_i | b_i;
      OP_XOR: res = a_i ^ b_i;
      OP_SGX: res = {{EXT{b_i[SGX_W-1]}}, b_i[SGX_W-1:0]};
      OP_SHL: begin
        res = {b_i[W-2:0], 1'b0};
        c_f = b_i[MSB];
      end
      OP_SHR: begin
        res = {1'b0, b_i[W-1:1]};
        c_f = b_i[0];
      end
      default: res = '0;
    endcase
  end

  assign res_o     = res;
  assign flags_o.n = res[MSB];
  assign flags_o.z = (res == '0);
  assign flags_o.v = v_f;
  assign flags_o.c = c_f;

endmodule

// File: rtl/status_reg.sv
module status_reg
  import alu_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   upd_i,
  input  flags_t upd_flags_i,
  input  logic   we_i,
  input  flags_t wdata_i,
  output flags_t q_o
);

  flags_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (we_i) q <= wdata_i;       // software load wins
    else if (upd_i) q <= upd_flags_i;
  end

  assign q_o = q;

  // R10
  stat_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (q_o == $past(wdata_i)));

  // R9
  stat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !upd_i) |=> $stable(q_o));

endmodule

// File: rtl/branch_eval.sv
module branch_eval
  import alu_pkg::*;
(
  input  br_cond_e cond_i,
  input  flags_t   flags_i,
  output logic     taken_o
);

  always_comb begin
    unique case (cond_i)
      BR_EQ:   taken_o = flags_i.z;
      BR_NE:   taken_o = ~flags_i.z;
      BR_NEG:  taken_o = flags_i.n;
      BR_OVF:  taken_o = flags_i.v;
      BR_CRY:  taken_o = flags_i.c;
      BR_ALW:  taken_o = 1'b1;
      default: taken_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import alu_pkg::*;
#(
  parameter int unsigned W     = 16,
  parameter int unsigned SGX_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [2:0]        op_i,
  input  logic [W-1:0]      src_a_i,
  input  logic [W-1:0]      src_b_i,
  input  logic [W-1:0]      imm_i,
  input  logic              use_imm_i,
  input  logic [2:0]        cond_i,
  input  logic              stat_we_i,
  input  logic [FLAG_W-1:0] stat_wdata_i,
  output logic [W-1:0]      result_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              br_taken_o
);

  localparam int unsigned MSB = W - 1;

  logic [W-1:0] opnd_b;
  logic [W-1:0] alu_res;
  flags_t       alu_flags;
  flags_t       stat_q;
  logic [W-1:0] res_q;

  assign opnd_b = use_imm_i ? imm_i : src_b_i;

  alu_core #(.W(W), .SGX_W(SGX_W)) u_core (
    .op_i   (alu_op_e'(op_i)),
    .a_i    (src_a_i),
    .b_i    (opnd_b),
    .res_o  (alu_res),
    .flags_o(alu_flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         res_q <= '0;
    else if (op_valid_i) res_q <= alu_res;
  end

  status_reg u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .upd_i      (op_valid_i),
    .upd_flags_i(alu_flags),
    .we_i       (stat_we_i),
    .wdata_i    (flags_t'(stat_wdata_i)),
    .q_o        (stat_q)
  );

  branch_eval u_br (
    .cond_i (br_cond_e'(cond_i)),
    .flags_i(stat_q),
    .taken_o(br_taken_o)
  );

  assign result_o = res_q;
  assign flags_o  = stat_q;

  // R8
  zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !stat_we_i) |=> (flags_o[2] == (result_o == '0)));

  // R8
  neg_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !stat_we_i) |=> (flags_o[3] == result_o[MSB]));

  // R5
  logic_vc_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !stat_we_i && (op_i inside {3'd2, 3'd3, 3'd4, 3'd5}))
      |=> (flags_o[1:0] == 2'b00));

  // R9
  res_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> $stable(result_o));

  // R11
  br_always_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == 3'd5) |-> br_taken_o);

endmodule

// File: tb/sim_flag_alu.sv
`timescale 1ns/100ps
module sim_flag_alu;

  typedef struct {
    logic [15:0] res;
    logic [3:0]  flg;
    int          rq;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [15:0] src_a = '0, src_b = '0, imm = '0;
  logic        use_imm = 1'b0;
  logic [2:0]  cond = '0;
  logic        stat_we = 1'b0;
  logic [3:0]  stat_wd = '0;
  logic [15:0] result;
  logic [3:0]  flags;
  logic        br_taken;

  int n_chk = 0, n_fail = 0;
  logic issued = 1'b0;
  logic done = 1'b0;
  exp_t q[$];
  logic [15:0] m_res = '0;
  logic [3:0]  m_flg = '0;

  always #4 clk = ~clk;

  flag_alu u0 (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_i(op),
    .src_a_i(src_a), .src_b_i(src_b), .imm_i(imm), .use_imm_i(use_imm),
    .cond_i(cond), .stat_we_i(stat_we), .stat_wdata_i(stat_wd),
    .result_o(result), .flags_o(flags), .br_taken_o(br_taken)
  );

  task automatic check(input int rq, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // reference model written from the requirements: returns {N,Z,V,C,result}
  function automatic logic [19:0] model(input logic [2:0] o, input logic [15:0] a, input logic [15:0] b);
    logic [16:0] w;
    logic [15:0] r;
    logic v, c;
    v = 1'b0; c = 1'b0; r = '0;
    case (o)
      3'd0: begin w = a + b; r = w[15:0]; c = w[16]; v = (a[15] == b[15]) && (r[15] != a[15]); end
      3'd1: begin r = a - b; c = (a >= b); v = (a[15] != b[15]) && (r[15] != a[15]); end
      3'd2: r = a & b;
      3'd3: r = a | b;
      3'd4: r = a ^ b;
      3'd5: r = {{8{b[7]}}, b[7:0]};
      3'd6: begin r = b << 1; c = b[15]; end
      default: begin r = b >> 1; c = b[0]; end
    endcase
    return {r[15], (r == 16'h0), v, c, r};
  endfunction

  task automatic drive(input logic [2:0] o, input logic [15:0] a, input logic [15:0] b,
                       input logic [15:0] im, input logic ui, input logic we,
                       input logic [3:0] wd, input int rq);
    logic [19:0] m;
    @(negedge clk);
    op_valid = 1'b1; op = o; src_a = a; src_b = b; imm = im; use_imm = ui;
    stat_we = we; stat_wd = wd;
    m = model(o, a, ui ? im : b);
    m_res = m[15:0];
    m_flg = we ? wd : m[19:16];
    q.push_back('{m_res, m_flg, rq});
    issued = 1'b1;
  endtask

  task automatic load_stat(input logic [3:0] wd);
    @(negedge clk);
    op_valid = 1'b0; stat_we = 1'b1; stat_wd = wd;
    m_flg = wd;
    q.push_back('{m_res, m_flg, 10});
    issued = 1'b1;
  endtask

  // idle cycle: expects hold (R9), sweeps all branch codes (R11)
  task automatic idle_br;
    logic exp_t_;
    @(negedge clk);
    op_valid = 1'b0; stat_we = 1'b0;
    src_a = 16'hDEAD; src_b = 16'hBEEF; imm = 16'h1234;
    q.push_back('{m_res, m_flg, 9});
    issued = 1'b1;
    for (int k = 0; k < 8; k++) begin
      cond = 3'(k);
      #0.3;
      case (k)
        0: exp_t_ = m_flg[2];
        1: exp_t_ = ~m_flg[2];
        2: exp_t_ = m_flg[3];
        3: exp_t_ = m_flg[1];
        4: exp_t_ = m_flg[0];
        5: exp_t_ = 1'b1;
        default: exp_t_ = 1'b0;
      endcase
      check(11, $sformatf("branch code %0d", k), {15'h0, br_taken}, {15'h0, exp_t_});
    end
  endtask

  // monitor: one expected item per issued cycle, compared after the edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      if (issued) begin
        #1;
        if (q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R9 scoreboard empty: actual %h expected item", result);
        end else begin
          e = q.pop_front();
          check(e.rq, "result", result, e.res);
          check(e.rq, "flags", {12'h0, flags}, {12'h0, e.flg});
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R9 watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(1, "reset result", result, 16'h0);
    check(1, "reset flags", {12'h0, flags}, 16'h0);
    rst_n = 1'b1;
    idle_br;                                                  // R11 on reset flags
    drive(3'd0, 16'h7FFF, 16'h0001, 16'h0, 1'b0, 1'b0, 4'h0, 3);  // R3 signed overflow
    idle_br;
    drive(3'd0, 16'hFFFF, 16'h0001, 16'h0, 1'b0, 1'b0, 4'h0, 3);  // R3 carry, zero
    idle_br;
    drive(3'd0, 16'h1234, 16'hFFFF, 16'h0042, 1'b1, 1'b0, 4'h0, 2); // R2 immediate
    drive(3'd0, 16'h1234, 16'h0042, 16'hFFFF, 1'b0, 1'b0, 4'h0, 2); // R2 register
    drive(3'd1, 16'h0005, 16'h0005, 16'h0, 1'b0, 1'b0, 4'h0, 4);  // R4 equal, no borrow
    idle_br;
    drive(3'd1, 16'h0003, 16'h0005, 16'h0, 1'b0, 1'b0, 4'h0, 4);  // R4 borrow
    idle_br;
    drive(3'd1, 16'h8000, 16'h0001, 16'h0, 1'b0, 1'b0, 4'h0, 4);  // R4 overflow
    idle_br;
    drive(3'd2, 16'hF0F0, 16'h3C3C, 16'h0, 1'b0, 1'b0, 4'h0, 5);  // R5 and
    drive(3'd3, 16'hF000, 16'h000F, 16'h0, 1'b0, 1'b0, 4'h0, 5);  // R5 or
    drive(3'd4, 16'hAAAA, 16'hAAAA, 16'h0, 1'b0, 1'b0, 4'h0, 5);  // R5 xor zero
    idle_br;
    drive(3'd5, 16'hFFFF, 16'h0080, 16'h0, 1'b0, 1'b0, 4'h0, 6);  // R6 negative byte
    drive(3'd5, 16'h0000, 16'h0000, 16'h127F, 1'b1, 1'b0, 4'h0, 6); // R6 positive via imm
    drive(3'd6, 16'h0000, 16'h8001, 16'h0, 1'b0, 1'b0, 4'h0, 7);  // R7 shl carry out
    idle_br;
    drive(3'd7, 16'h0000, 16'h0001, 16'h0, 1'b0, 1'b0, 4'h0, 7);  // R7 shr to zero
    idle_br;
    drive(3'd7, 16'h0000, 16'h8000, 16'h0, 1'b0, 1'b0, 4'h0, 8);  // R8 logical fill
    drive(3'd0, 16'h0001, 16'h0001, 16'h0, 1'b0, 1'b1, 4'hA, 10); // R10 load beats op
    idle_br;
    load_stat(4'h5);                                          // R10 load alone
    idle_br;
    load_stat(4'hF);
    idle_br;
    idle_br;                                                  // R9 hold
    @(negedge clk);
    issued = 1'b0;
    @(posedge clk);
    #2;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule